// File: doc/BRIEF.md
# Descending Word Stack Controller

This block keeps a stack pointer over a small byte-addressed memory and carries out push, pop, pointer-load and idle commands on 16-bit words. The stack is full-descending. The pointer always names the lowest byte of the word on top of the stack. It starts at a configured base address, one step above the first word. A push stores its word in the two bytes just below the pointer and then lowers the pointer by two. A pop returns the word at the pointer and then raises the pointer by two. The low byte of a word sits at the lower address.

A client offers one command at a time on a valid/ready handshake. Once a command is accepted, the controller spends exactly two cycles on memory: one for the low byte and one for the high byte. It then reports the outcome on one-cycle strobes. A popped word comes with a valid strobe. A push that would take the pointer below the configured limit is refused and raises an overflow strobe. A pop at the base is refused and raises an underflow strobe. A refused command leaves the pointer where it was.

The control is a three-state machine. IDLE is the only state with ready high. IDLE goes to LOW on an accepted command. LOW, where the low byte is moved, always goes to HIGH. HIGH, where the high byte is moved and the outcome is registered, always returns to IDLE.

Top module: `wstack_ctrl`

## Requirements
- R1: During and straight after reset, the pointer equals BASE, empty is 1, cmd_ready is 1, and rd_valid, ovf_flag and unf_flag are 0.
- R2: A push (cmd_op 00) accepted while the pointer is at least LIMIT+2 stores cmd_data at pointer-2 (low byte) and pointer-1 (high byte), and the pointer drops by 2.
- R3: A pop (cmd_op 01) accepted while the pointer differs from BASE returns the word at the pointer on rd_data with rd_valid high for one cycle, and the pointer rises by 2. Words come back in reverse order of pushing.
- R4: A push accepted while the pointer is below LIMIT+2 pulses ovf_flag for one cycle, leaves the pointer unchanged, and leaves the stored words intact.
- R5: A pop accepted while the pointer equals BASE pulses unf_flag for one cycle, raises no rd_valid, and leaves the pointer unchanged.
- R6: empty is 1 exactly when the pointer equals BASE.
- R7: A load (cmd_op 10) sets the pointer to the low ADDR_W bits of cmd_data with bit 0 forced to 0. It raises no strobe.
- R8: cmd_ready is high only in IDLE. After an accepted command it is low for exactly two cycles. The pointer and the strobes change on the clock edge that ends the second busy cycle.
- R9: Code 11 is an idle command. It takes the same two busy cycles and changes neither the pointer nor any strobe.
- R10: At most one of rd_valid, ovf_flag and unf_flag is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle and able to accept |
| cmd_op | input | 2 | 00 push, 01 pop, 10 load pointer, 11 idle |
| cmd_data | input | 16 | Word to push, or new pointer value for a load |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds a popped word |
| rd_data | output | 16 | Last popped word |
| sp | output | ADDR_W | Current stack pointer |
| empty | output | 1 | Pointer equals BASE |
| ovf_flag | output | 1 | One-cycle strobe: push refused at the limit |
| unf_flag | output | 1 | One-cycle strobe: pop refused at the base |

## Verification
The bench builds the block with its defaults: an 8-bit pointer over a 256-byte memory, BASE 64 and LIMIT 16. With these values the stack holds 24 words, so a 25th push reaches the overflow refusal within a few hundred cycles. A behavioural model with its own byte memory tracks the pointer and the empty flag and compares them on every clock. The same model predicts the word returned by pops after pointer loads into previously written regions, including a load with an odd value.

// File: rtl/wstk_pkg.sv
package wstk_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_LOAD = 2'b10,
        OP_NOP  = 2'b11
    } wstk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LO   = 2'b01,
        ST_HI   = 2'b10
    } wstk_state_e;

    localparam int unsigned WORD_BYTES = 2;
    localparam int unsigned WORD_W     = 8 * WORD_BYTES;

endpackage

// File: rtl/wstk_bytemem.sv
module wstk_bytemem #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdat,
    output logic [7:0]        rdat
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdat;
        end
    end

    assign rdat = cells[addr];

endmodule

// File: rtl/wstk_ptr.sv
module wstk_ptr #(
    parameter int ADDR_W = 8,
    parameter int BASE   = 64,
    parameter int LIMIT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [ADDR_W-1:0] nxt,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_dn,
    output logic [ADDR_W-1:0] sp_up,
    output logic              at_base,
    output logic              push_blk
);
    import wstk_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W:0]   FLOOR   = {1'b0, LIMIT_A} + {1'b0, STEP};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= BASE_A;
        end else if (upd) begin
            sp <= nxt;
        end
    end

    always_comb begin
        sp_dn    = sp - STEP;
        sp_up    = sp + STEP;
        at_base  = (sp == BASE_A);
        push_blk = ({1'b0, sp} < FLOOR);
    end

    // R1 / R7: the pointer stays word aligned
    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        sp[0] == 1'b0);

    // R1: reset value of the pointer
    a_r1_reset_base: assert property (@(posedge clk)
        !rst_n |=> sp == BASE_A);

endmodule

// File: rtl/wstk_ctrl_fsm.sv
module wstk_ctrl_fsm #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [15:0]       cmd_data,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] sp_dn,
    input  logic [ADDR_W-1:0] sp_up,
    input  logic              at_base,
    input  logic              push_blk,
    input  logic [7:0]        mem_rdat,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdat,
    output logic              sp_upd,
    output logic [ADDR_W-1:0] sp_nxt,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic              ovf_flag,
    output logic              unf_flag
);
    import wstk_pkg::*;

    wstk_state_e state_q, state_d;
    wstk_op_e    op_q, op_in;
    logic [15:0] word_q;
    logic [7:0]  lo_q;
    logic        refuse_q;
    logic        accept;
    logic        wr_side;

    assign op_in  = wstk_op_e'(cmd_op);
    assign accept = (state_q == ST_IDLE) && cmd_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_LO;
            ST_LO:   state_d = ST_HI;
            ST_HI:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // command capture and low-byte holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NOP;
            word_q   <= '0;
            refuse_q <= 1'b0;
            lo_q     <= '0;
        end else begin
            if (accept) begin
                op_q     <= op_in;
                word_q   <= cmd_data;
                refuse_q <= ((op_in == OP_PUSH) && push_blk) ||
                            ((op_in == OP_POP)  && at_base);
            end
            if (state_q == ST_LO) begin
                lo_q <= mem_rdat;
            end
        end
    end

    // registered outcome strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            if (state_q == ST_HI) begin
                unique case (op_q)
                    OP_POP: begin
                        if (refuse_q) begin
                            unf_flag <= 1'b1;
                        end else begin
                            rd_valid <= 1'b1;
                            rd_data  <= {mem_rdat, lo_q};
                        end
                    end
                    OP_PUSH: begin
                        if (refuse_q) ovf_flag <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // memory and pointer steering
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        wr_side   = (op_q == OP_PUSH);
        mem_addr  = (wr_side ? sp_dn : sp) + ADDR_W'(state_q == ST_HI);
        mem_we    = wr_side && !refuse_q && (state_q != ST_IDLE);
        mem_wdat  = (state_q == ST_HI) ? word_q[15:8] : word_q[7:0];
        sp_upd    = (state_q == ST_HI) && !refuse_q && (op_q != OP_NOP);
        unique case (op_q)
            OP_PUSH: sp_nxt = sp_dn;
            OP_POP:  sp_nxt = sp_up;
            OP_LOAD: sp_nxt = {word_q[ADDR_W-1:1], 1'b0};
            default: sp_nxt = sp;
        endcase
    end

    // R8: two busy cycles follow every acceptance
    a_r8_busy_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r8_busy_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(cmd_ready)) |=> !cmd_ready);

    a_r8_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !$past(cmd_ready)) |=> cmd_ready);

    // R10: outcome strobes are exclusive
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, ovf_flag, unf_flag}));

    // R8: strobes only right after the last busy cycle
    a_r8_strobe_time: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || ovf_flag || unf_flag) |-> (cmd_ready && !$past(cmd_ready)));

endmodule

// File: rtl/wstack_ctrl.sv
module wstack_ctrl #(
    parameter int ADDR_W = 8,
    parameter int BASE   = 64,
    parameter int LIMIT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [15:0]       cmd_data,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] sp,
    output logic              empty,
    output logic              ovf_flag,
    output logic              unf_flag
);
    logic [ADDR_W-1:0] sp_dn, sp_up, sp_nxt, mem_addr;
    logic              at_base, push_blk, sp_upd, mem_we;
    logic [7:0]        mem_wdat, mem_rdat;

    wstk_ptr #(.ADDR_W(ADDR_W), .BASE(BASE), .LIMIT(LIMIT)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (sp_upd),
        .nxt      (sp_nxt),
        .sp       (sp),
        .sp_dn    (sp_dn),
        .sp_up    (sp_up),
        .at_base  (at_base),
        .push_blk (push_blk)
    );

    wstk_bytemem #(.ADDR_W(ADDR_W)) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdat (mem_wdat),
        .rdat (mem_rdat)
    );

    wstk_ctrl_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .sp        (sp),
        .sp_dn     (sp_dn),
        .sp_up     (sp_up),
        .at_base   (at_base),
        .push_blk  (push_blk),
        .mem_rdat  (mem_rdat),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdat  (mem_wdat),
        .sp_upd    (sp_upd),
        .sp_nxt    (sp_nxt),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    assign empty = at_base;

    // R3: a returned word raises the pointer by one word
    a_r3_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> sp == ADDR_W'($past(sp) + ADDR_W'(2)));

    // R4: refused push keeps the pointer
    a_r4_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> sp == $past(sp));

    // R5: refused pop keeps the pointer, and only happens at the base
    a_r5_unf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (sp == $past(sp)) && empty);

    // R8: pointer never moves while a command is being accepted or idle
    a_r8_sp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_ready) && $past(rst_n)) |-> $stable(sp));

endmodule

// File: tb/wstack_ctrl_test.sv
module wstack_ctrl_test;

    localparam int BASE  = 64;
    localparam int LIMIT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b11;
    logic [15:0] cmd_data = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [7:0]  sp;
    logic        empty;
    logic        ovf_flag;
    logic        unf_flag;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  mon_en  = 1'b0;
    bit  finished = 1'b0;
    int  msp = BASE;
    logic [7:0] bmem [0:255];

    always #2.5 clk = ~clk;

    wstack_ctrl #(.ADDR_W(8), .BASE(BASE), .LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .sp(sp), .empty(empty), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison of pointer and empty against the model (R6)
    always @(negedge clk) begin
        if (mon_en) begin
            #1;
            chk(int'(sp) == msp, "R2/R3 pointer track", int'(sp), msp);
            chk(empty == (msp == BASE), "R6 empty", int'(empty), int'(msp == BASE));
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [15:0] dat, input string tag);
        bit          e_rv = 0, e_ov = 0, e_un = 0;
        logic [15:0] e_dat = '0;
        int          nsp = msp;
        case (op)
            2'b00: if (msp < LIMIT + 2) e_ov = 1; else nsp = msp - 2;
            2'b01: if (msp == BASE) e_un = 1;
                   else begin e_rv = 1; e_dat = {bmem[msp+1], bmem[msp]}; nsp = msp + 2; end
            2'b10: nsp = int'(dat[7:0]) & 32'hFE;
            default: ;
        endcase
        @(negedge clk);
        chk(cmd_ready == 1'b1, {tag, " R8 ready idle"}, int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = dat;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        chk(cmd_ready == 1'b0, {tag, " R8 busy 1"}, int'(cmd_ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b0, {tag, " R8 busy 2"}, int'(cmd_ready), 0);
        chk({rd_valid, ovf_flag, unf_flag} == 3'b000, {tag, " R8 no early strobe"},
            int'({rd_valid, ovf_flag, unf_flag}), 0);
        @(posedge clk);
        @(negedge clk);
        if (op == 2'b00 && !e_ov) begin
            bmem[msp-2] = dat[7:0];
            bmem[msp-1] = dat[15:8];
        end
        msp = nsp;
        chk(cmd_ready == 1'b1, {tag, " R8 ready back"}, int'(cmd_ready), 1);
        chk(rd_valid == e_rv, {tag, " R3 rd_valid"}, int'(rd_valid), int'(e_rv));
        chk(ovf_flag == e_ov, {tag, " R4 ovf_flag"}, int'(ovf_flag), int'(e_ov));
        chk(unf_flag == e_un, {tag, " R5 unf_flag"}, int'(unf_flag), int'(e_un));
        chk($onehot0({rd_valid, ovf_flag, unf_flag}), {tag, " R10 exclusive"},
            int'({rd_valid, ovf_flag, unf_flag}), 0);
        if (e_rv) chk(rd_data == e_dat, {tag, " R3 rd_data"}, int'(rd_data), int'(e_dat));
        @(negedge clk);
        chk({rd_valid, ovf_flag, unf_flag} == 3'b000, {tag, " R8 strobe one cycle"},
            int'({rd_valid, ovf_flag, unf_flag}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(sp) == BASE, "R1 reset sp", int'(sp), BASE);
        chk(empty && cmd_ready && !rd_valid && !ovf_flag && !unf_flag, "R1 reset outputs",
            int'({empty, cmd_ready, rd_valid, ovf_flag, unf_flag}), 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(sp) == BASE && empty && cmd_ready, "R1 after release",
            int'(sp), BASE);
        mon_en = 1'b1;

        run_cmd(2'b01, 16'h0000, "R5 pop on empty");
        run_cmd(2'b00, 16'd9,    "R2 push 9");
        chk(int'(sp) == 62, "R2 sp after 9", int'(sp), 62);
        run_cmd(2'b00, 16'd10,   "R2 push 10");
        chk(int'(sp) == 60, "R2 sp after 10", int'(sp), 60);
        run_cmd(2'b01, 16'h0000, "R3 pop 10");
        run_cmd(2'b01, 16'h0000, "R3 pop 9");
        chk(empty == 1'b1, "R6 empty after drain", int'(empty), 1);
        run_cmd(2'b11, 16'h0042, "R9 idle code");

        for (int i = 0; i < 24; i++) begin
            run_cmd(2'b00, 16'(16'hA000 + i * 16'h0137), "R2 fill");
        end
        chk(int'(sp) == LIMIT, "R4 sp at limit", int'(sp), LIMIT);
        run_cmd(2'b00, 16'hDEAD, "R4 push refused");
        run_cmd(2'b01, 16'h0000, "R4 top intact");
        for (int i = 0; i < 11; i++) begin
            run_cmd(2'b01, 16'h0000, "R3 drain");
        end
        run_cmd(2'b10, 16'h012E, "R7 load 2e");
        run_cmd(2'b01, 16'h0000, "R7 pop after load");
        run_cmd(2'b10, 16'h0029, "R7 load odd");
        chk(int'(sp) == 40, "R7 bit0 cleared", int'(sp), 40);
        run_cmd(2'b01, 16'h0000, "R7 pop at 40");
        run_cmd(2'b10, 16'h0040, "R7 load base");
        run_cmd(2'b01, 16'h0000, "R5 pop at base");
        run_cmd(2'b00, 16'h55AA, "R2 push after load");
        run_cmd(2'b01, 16'h0000, "R3 pop after load");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule